// File: doc/BRIEF.md
# Closed Caption Line Encoder

This block generates the digital data-level sequence of a closed caption line for a video encoder's luma path. On a chosen line of the first field, on a chosen line of the second field, or on both, it overrides the luma samples. It first sends a clock run-in, then three start bits, then two 7-bit characters. The block adds an odd-parity bit to each character. For every pixel sample the output gives a valid flag and a high/low level. The luma path maps the high level to 50 IRE and the low level to blanking.

Software may write the four character registers at any time through a simple write port. A write lands in a shadow copy. The shadow set is moved into the active set only on the vertical sync strobe, so a caption pair can never be split across frames. The two override outputs are a plain per-sample stream with no ready signal. The luma path cannot apply back-pressure, and the block moves forward only on samples where `pix_en` is high.

Top module: `cc_line_encoder`

## Requirements
- R1: When `cc_mode[0]`=1, a `hsync_start` sample with `field2`=0 and `line_num`=LINE_F1 (default 21) starts a frame carrying active characters 0 and 1.
- R2: When `cc_mode[1]`=1, a `hsync_start` sample with `field2`=1 and `line_num`=LINE_F2 (default 284) starts a frame carrying active characters 2 and 3.
- R3: A write with `chr_wr_en` stores `chr_wr_data` in shadow register `chr_wr_addr`. The active set takes the whole shadow set on a clock where `vsync_pulse` is high, and changes on no other clock.
- R4: Mode code 00 disables both fields. A field whose mode bit is 0 gives no override (`ovr_valid` stays 0) on its caption line.
- R5: Frame bit positions 0..13 form the run-in, alternating 1,0 and starting with 1 (seven cycles). Positions 14, 15 and 16 are the start bits 0, 0, 1.
- R6: Positions 17..23 carry character 1 with bit 0 first, and position 24 is its parity bit. Positions 25..31 carry character 2 with bit 0 first, and position 32 is its parity bit. Each parity bit makes the 8-bit group have an odd number of ones.
- R7: Count the trigger sample as sample 0. Data sample s = n - START_DLY (default 140) carries frame bit floor(s*PER_DEN/PER_NUM), with defaults 16/429, which gives about 26.8 samples per bit. The override ends once that index reaches 33.
- R8: The outputs change only on clocks where `pix_en` is high. The output for sample n appears after that sample's clock edge. `ovr_level` is 0 whenever `ovr_valid` is 0.
- R9: After reset all character registers hold 0, and `ovr_valid` and `ovr_level` are 0.
- R10: A `hsync_start` on any other line, or in the other field, starts nothing.
- R11: The characters are captured when a line starts. A write and a vsync that come during a frame do not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_en | input | 1 | Pixel sample enable |
| hsync_start | input | 1 | Marks the sample at the leading edge of horizontal sync |
| line_num | input | LINE_W | Current line number within the field |
| field2 | input | 1 | 1 = second field |
| vsync_pulse | input | 1 | Vertical sync strobe that loads the active characters |
| cc_mode | input | 2 | bit0 enables field 1, bit1 enables field 2 |
| chr_wr_en | input | 1 | Character register write strobe |
| chr_wr_addr | input | 2 | Character index: 0,1 = field 1; 2,3 = field 2 |
| chr_wr_data | input | CHAR_W | Character code |
| ovr_valid | output | 1 | Luma override active for this sample |
| ovr_level | output | 1 | 1 = 50 IRE, 0 = blanking |

## Verification
The bench runs caption lines with three sample-enable densities: every clock, every second clock and every third clock. Each one shows whether bit timing counts samples or clocks. The characters include all zeros (reset state, both parity bits 1), all ones (parity 0) and mixed codes. Together they separate the parity polarity, the bit order and the choice of field pair. Further lines check the wrong line, the wrong field and each mode code. One sequence writes the registers without a vsync, and another writes them together with a vsync in the middle of a line. These show the shadow/active split and the capture of the characters at the start of the line.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_SEND = 2'd2
  } seq_state_t;

  localparam int MODE_F1_BIT = 0;
  localparam int MODE_F2_BIT = 1;
  localparam int START_BITS  = 3;
endpackage

// File: rtl/cc_char_bank.sv
module cc_char_bank #(
  parameter int CHAR_W  = 7,
  parameter int N_CHARS = 4,
  localparam int AW     = $clog2(N_CHARS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [CHAR_W-1:0]           wr_data,
  input  logic                        vsync,
  output logic [N_CHARS*CHAR_W-1:0]   active_o
);
  logic [N_CHARS*CHAR_W-1:0] shadow_flat;

  for (genvar g = 0; g < N_CHARS; g++) begin : g_chr
    logic [CHAR_W-1:0] shadow_q;
    logic [CHAR_W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
      end else if (wr_en && (wr_addr == AW'(g))) begin
        shadow_q <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active_q <= '0;
      end else if (vsync) begin
        active_q <= shadow_q;
      end
    end

    assign shadow_flat[g*CHAR_W +: CHAR_W] = shadow_q;
    assign active_o[g*CHAR_W +: CHAR_W]    = active_q;
  end

  // R3: active set moves only on vsync, and then takes the shadow set
  p_active_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(active_o));
  p_active_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (active_o == $past(shadow_flat)));
endmodule

// File: rtl/cc_bit_clock.sv
module cc_bit_clock #(
  parameter int PER_NUM = 429,
  parameter int PER_DEN = 16,
  localparam int ACC_W  = $clog2(PER_NUM + PER_DEN) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic tick
);
  localparam logic [ACC_W-1:0] NUM_L = ACC_W'(PER_NUM);
  localparam logic [ACC_W-1:0] DEN_L = ACC_W'(PER_DEN);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  assign acc_sum = acc_q + DEN_L;
  assign tick    = adv && (acc_sum >= NUM_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
    end else if (adv) begin
      acc_q <= tick ? (acc_sum - NUM_L) : acc_sum;
    end
  end

  // R7: remainder of the fractional bit period stays below one period
  p_acc_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < NUM_L);
endmodule

// File: rtl/cc_line_seq.sv
module cc_line_seq
  import cc_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int CHAR_W    = 7,
  parameter int LINE_F1   = 21,
  parameter int LINE_F2   = 284,
  parameter int START_DLY = 140,
  parameter int RUNIN_CYC = 7,
  localparam int N_CHARS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pix_en,
  input  logic                      hsync_start,
  input  logic [LINE_W-1:0]         line_num,
  input  logic                      field2,
  input  logic [1:0]                mode,
  input  logic [N_CHARS*CHAR_W-1:0] chars,
  input  logic                      tick,
  output logic                      clr_acc,
  output logic                      adv_acc,
  output logic                      ovr_valid,
  output logic                      ovr_level
);
  localparam int RUNIN_BITS = 2 * RUNIN_CYC;
  localparam int OFF1       = RUNIN_BITS + START_BITS;
  localparam int OFF2       = OFF1 + CHAR_W + 1;
  localparam int FRAME_BITS = OFF2 + CHAR_W + 1;
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);
  localparam int DLY_W      = $clog2(START_DLY + 1);
  localparam logic [LINE_W-1:0] F1_LINE  = LINE_W'(LINE_F1);
  localparam logic [LINE_W-1:0] F2_LINE  = LINE_W'(LINE_F2);
  localparam logic [DLY_W-1:0]  DLY_LAST = DLY_W'(START_DLY - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(FRAME_BITS - 1);

  seq_state_t              state_q;
  logic [DLY_W-1:0]        dly_q;
  logic [BIT_W-1:0]        bit_q;
  logic [FRAME_BITS-1:0]   frame_q;
  logic [FRAME_BITS-1:0]   frame_d;
  logic [CHAR_W-1:0]       c1;
  logic [CHAR_W-1:0]       c2;
  logic                    hit_f1;
  logic                    hit_f2;
  logic                    trig;

  assign hit_f1 = !field2 && (line_num == F1_LINE) && mode[MODE_F1_BIT];
  assign hit_f2 =  field2 && (line_num == F2_LINE) && mode[MODE_F2_BIT];
  assign trig   = pix_en && hsync_start && (state_q == SQ_IDLE) && (hit_f1 || hit_f2);

  assign c1 = field2 ? chars[2*CHAR_W +: CHAR_W] : chars[0 +: CHAR_W];
  assign c2 = field2 ? chars[3*CHAR_W +: CHAR_W] : chars[CHAR_W +: CHAR_W];

  always_comb begin
    frame_d = '0;
    for (int i = 0; i < RUNIN_BITS; i++) begin
      frame_d[i] = ((i % 2) == 0);
    end
    frame_d[OFF1 - 1]           = 1'b1;
    frame_d[OFF1 +: CHAR_W]     = c1;
    frame_d[OFF1 + CHAR_W]      = ~^c1;
    frame_d[OFF2 +: CHAR_W]     = c2;
    frame_d[OFF2 + CHAR_W]      = ~^c2;
  end

  assign clr_acc = (state_q == SQ_WAIT);
  assign adv_acc = pix_en && (state_q == SQ_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      dly_q     <= '0;
      bit_q     <= '0;
      frame_q   <= '0;
      ovr_valid <= 1'b0;
      ovr_level <= 1'b0;
    end else if (pix_en) begin
      case (state_q)
        SQ_IDLE: begin
          ovr_valid <= 1'b0;
          ovr_level <= 1'b0;
          if (trig) begin
            state_q <= SQ_WAIT;
            dly_q   <= DLY_W'(1);
            frame_q <= frame_d;
          end
        end
        SQ_WAIT: begin
          ovr_valid <= 1'b0;
          ovr_level <= 1'b0;
          if (dly_q == DLY_LAST) begin
            state_q <= SQ_SEND;
            bit_q   <= '0;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        SQ_SEND: begin
          ovr_valid <= 1'b1;
          ovr_level <= frame_q[bit_q];
          if (tick) begin
            if (bit_q == BIT_LAST) begin
              state_q <= SQ_IDLE;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R8: outputs hold between sample enables; level low when not valid
  p_hold_between_samples_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(ovr_valid) && $stable(ovr_level)));
  p_level_low_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_valid |-> !ovr_level);
  // R5: the first override sample is the high half of the run-in
  p_runin_starts_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_valid) |-> ovr_level);
  // R4: mode 00 never leaves idle
  p_mode_off_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && mode == 2'b00) |=> (state_q == SQ_IDLE));
  // R7: bit index never runs past the frame
  p_bit_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= BIT_LAST);
endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder #(
  parameter int LINE_W    = 10,
  parameter int CHAR_W    = 7,
  parameter int LINE_F1   = 21,
  parameter int LINE_F2   = 284,
  parameter int START_DLY = 140,
  parameter int PER_NUM   = 429,
  parameter int PER_DEN   = 16,
  parameter int RUNIN_CYC = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              hsync_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field2,
  input  logic              vsync_pulse,
  input  logic [1:0]        cc_mode,
  input  logic              chr_wr_en,
  input  logic [1:0]        chr_wr_addr,
  input  logic [CHAR_W-1:0] chr_wr_data,
  output logic              ovr_valid,
  output logic              ovr_level
);
  localparam int N_CHARS = 4;

  logic [N_CHARS*CHAR_W-1:0] active_chars;
  logic clr_acc;
  logic adv_acc;
  logic bit_tick;

  cc_char_bank #(
    .CHAR_W (CHAR_W),
    .N_CHARS(N_CHARS)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (chr_wr_en),
    .wr_addr (chr_wr_addr),
    .wr_data (chr_wr_data),
    .vsync   (vsync_pulse),
    .active_o(active_chars)
  );

  cc_bit_clock #(
    .PER_NUM(PER_NUM),
    .PER_DEN(PER_DEN)
  ) u_bclk (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_acc),
    .adv  (adv_acc),
    .tick (bit_tick)
  );

  cc_line_seq #(
    .LINE_W   (LINE_W),
    .CHAR_W   (CHAR_W),
    .LINE_F1  (LINE_F1),
    .LINE_F2  (LINE_F2),
    .START_DLY(START_DLY),
    .RUNIN_CYC(RUNIN_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .hsync_start(hsync_start),
    .line_num   (line_num),
    .field2     (field2),
    .mode       (cc_mode),
    .chars      (active_chars),
    .tick       (bit_tick),
    .clr_acc    (clr_acc),
    .adv_acc    (adv_acc),
    .ovr_valid  (ovr_valid),
    .ovr_level  (ovr_level)
  );
endmodule

// File: tb/cc_line_encoder_tb.sv
module cc_line_encoder_tb;
  localparam int LF1 = 21;
  localparam int LF2 = 284;
  localparam int DLY = 140;
  localparam int NUM = 429;
  localparam int DEN = 16;
  localparam int FRAME = 33;
  localparam int NS = DLY + (FRAME * NUM + DEN - 1) / DEN + 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0;
  logic hsync_start = 1'b0;
  logic [9:0] line_num = '0;
  logic field2 = 1'b0;
  logic vsync_pulse = 1'b0;
  logic [1:0] cc_mode = 2'b00;
  logic chr_wr_en = 1'b0;
  logic [1:0] chr_wr_addr = '0;
  logic [6:0] chr_wr_data = '0;
  logic ovr_valid;
  logic ovr_level;

  int n_checks = 0;
  int n_fail = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];
  logic [6:0] shadow_m[4];
  logic [6:0] active_m[4];

  always #4 clk = ~clk;

  cc_line_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hsync_start(hsync_start),
    .line_num(line_num), .field2(field2), .vsync_pulse(vsync_pulse),
    .cc_mode(cc_mode), .chr_wr_en(chr_wr_en), .chr_wr_addr(chr_wr_addr),
    .chr_wr_data(chr_wr_data), .ovr_valid(ovr_valid), .ovr_level(ovr_level)
  );

  // monitor: one expected item per sample-enabled edge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && pix_en) begin
        #2;
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R8: unexpected sample, got %b expected none", {ovr_valid, ovr_level});
        end else begin
          logic [1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({ovr_valid, ovr_level} !== e) begin
            n_fail++;
            $display("FAIL %s: got valid/level %b expected %b", t, {ovr_valid, ovr_level}, e);
          end
        end
      end
    end
  end

  function automatic logic exp_bit(int k, logic [6:0] a, logic [6:0] b);
    int ones;
    if (k < 14) return (k % 2) == 0;
    if (k < 16) return 1'b0;
    if (k == 16) return 1'b1;
    if (k < 24) return a[k - 17];
    if (k == 24) begin ones = $countones(a); return (ones % 2) == 0; end
    if (k < 32) return b[k - 25];
    ones = $countones(b);
    return (ones % 2) == 0;
  endfunction

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      pix_en = 1'b0; hsync_start = 1'b0; chr_wr_en = 1'b0; vsync_pulse = 1'b0;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [6:0] d);
    @(negedge clk);
    pix_en = 1'b0; hsync_start = 1'b0;
    chr_wr_en = 1'b1; chr_wr_addr = a; chr_wr_data = d;
    shadow_m[a] = d;
    @(negedge clk);
    chr_wr_en = 1'b0;
  endtask

  task automatic vsync();
    @(negedge clk);
    pix_en = 1'b0; hsync_start = 1'b0; vsync_pulse = 1'b1;
    for (int i = 0; i < 4; i++) active_m[i] = shadow_m[i];
    @(negedge clk);
    vsync_pulse = 1'b0;
  endtask

  task automatic put_sample(bit hs, logic [1:0] e, string t, int gap);
    @(negedge clk);
    pix_en = 1'b1; hsync_start = hs;
    exp_q.push_back(e);
    tag_q.push_back(t);
    repeat (gap) begin
      @(negedge clk);
      pix_en = 1'b0; hsync_start = 1'b0;
    end
  endtask

  task automatic run_line(int ln, bit f2, int gap, string tg, bit midwr);
    bit trig;
    logic [6:0] a;
    logic [6:0] b;
    trig = (!f2 && ln == LF1 && cc_mode[0]) || (f2 && ln == LF2 && cc_mode[1]);
    a = f2 ? active_m[2] : active_m[0];
    b = f2 ? active_m[3] : active_m[1];
    @(negedge clk);
    pix_en = 1'b0; line_num = 10'(ln); field2 = f2;
    for (int n = 0; n < NS; n++) begin
      logic [1:0] e;
      string t;
      int k;
      e = 2'b00;
      t = tg;
      if (trig && n >= DLY) begin
        k = ((n - DLY) * DEN) / NUM;
        if (k < FRAME) begin
          e = {1'b1, exp_bit(k, a, b)};
          t = (k < 17) ? {tg, " R5 R7"} : {tg, " R6 R7"};
        end else begin
          t = {tg, " R7 end"};
        end
      end
      put_sample(n == 0, e, t, gap);
      if (midwr && n == 300) begin
        wr(2'd0, 7'h2A);
        wr(2'd1, 7'h03);
        vsync();
      end
    end
    idle(4);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin shadow_m[i] = '0; active_m[i] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state of outputs
    n_checks++;
    if ({ovr_valid, ovr_level} !== 2'b00) begin
      n_fail++;
      $display("FAIL R9: got %b expected 00", {ovr_valid, ovr_level});
    end
    // R9 R1: reset characters are zero, parity bits then 1
    cc_mode = 2'b01;
    run_line(LF1, 1'b0, 1, "R9 R1", 1'b0);
    // R3: shadow writes without vsync leave the line unchanged
    wr(2'd0, 7'h41);
    wr(2'd1, 7'h5A);
    run_line(LF1, 1'b0, 1, "R3", 1'b0);
    vsync();
    run_line(LF1, 1'b0, 0, "R3 R1", 1'b0);
    // R4: field 2 disabled under mode 01
    run_line(LF2, 1'b1, 1, "R4", 1'b0);
    // R2: field 2 pair, parity corner values
    wr(2'd2, 7'h7F);
    wr(2'd3, 7'h00);
    vsync();
    cc_mode = 2'b10;
    run_line(LF2, 1'b1, 2, "R2", 1'b0);
    run_line(LF1, 1'b0, 1, "R4", 1'b0);
    // R10: wrong field or wrong line
    cc_mode = 2'b11;
    run_line(LF1, 1'b1, 0, "R10", 1'b0);
    run_line(LF1 - 1, 1'b0, 0, "R10", 1'b0);
    run_line(LF2, 1'b0, 0, "R10", 1'b0);
    // R4: mode 00
    cc_mode = 2'b00;
    run_line(LF1, 1'b0, 0, "R4", 1'b0);
    // R11: mid-line update does not disturb the running line
    cc_mode = 2'b11;
    run_line(LF1, 1'b0, 1, "R11", 1'b1);
    run_line(LF1, 1'b0, 1, "R11 R3", 1'b0);
    run_line(LF2, 1'b1, 0, "R2 R6", 1'b0);
    idle(6);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule